// File: doc/BRIEF.md
# Dual word-line SRAM controller with embedded read-only rows

This controller sits in front of an SRAM array whose rows carry two word-line enables, A and B. Every cell is tied by its wiring to one of the two lines, and that wiring forms a fixed pattern per row. Ordinary RAM accesses raise both lines and behave like a plain single-port SRAM. A read-only fetch gets the hard-wired pattern out of the cells without losing the row's RAM data.

A read-only fetch runs a fixed sequence. The controller first reads the row and keeps it in a side buffer. It then writes all ones through both lines, and then writes all zeros through line B alone. Only the cells tied to line A still hold a one. The row is read back as the result, and the buffered RAM word is written back before the response. Reads are held off while a sequence runs. One RAM write may be parked during a sequence and is applied only after the restore. The behavioural array model is inside the top module, and the two word-line enables are brought out for observation.

Top module: `rwl_rom_ram_ctrl`

## Requirements
- R1: After reset, req_ready_o is 1, rsp_valid_o is 0, both word-line enables are 0, and every row reads back as zero.
- R2: A RAM request (req_we_i=0, req_rom_i=0) raises both word-line enables in the cycle it is accepted. Its read data appears with rsp_valid_o exactly one cycle after acceptance. A write (req_we_i=1) updates the row and produces no response.
- R3: A read-only fetch (req_we_i=0, req_rom_i=1) answers with rsp_valid_o exactly 6 cycles after acceptance. The data is the row's wiring mask: bit i is 1 when cell i is tied to line A. The mask of row r is the WIRE_SEED parameter (default 32'hA5C30F96) rotated left by r positions.
- R4: In the 2nd cycle after acceptance of a fetch, the array is written with all ones and both lines high. In the 3rd cycle it is written with all zeros, with line A low and line B high.
- R5: After a fetch, a RAM read of the same row returns the RAM word it held before the fetch.
- R6: While a fetch is running, req_ready_o is 0 for any read request, RAM or read-only.
- R7: During a fetch, the first RAM write is accepted and parked. It is applied after the restore, so a later read returns the written value. A second write in the same fetch sees req_ready_o=0 and is not applied.
- R8: A request with req_we_i=1 is a RAM write even when req_rom_i=1.
- R9: A fetch leaves the RAM contents of every other row unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Request accepted this cycle when high with req_valid_i |
| req_rom_i | input | 1 | Read-only fetch select (ignored for writes) |
| req_we_i | input | 1 | Write request |
| req_addr_i | input | AW | Row address |
| req_wdata_i | input | DW | Write data |
| rsp_valid_o | output | 1 | One-cycle read response strobe |
| rsp_rdata_o | output | DW | Read data |
| wl_a_o | output | 1 | Word-line A enable driven to the array |
| wl_b_o | output | 1 | Word-line B enable driven to the array |

## Verification
Assertions check several properties on every cycle. Accepted RAM requests drive both lines. The ones phase and the zeros phase use the right lines and data. The restored word equals what the array returned in the save cycle. Reads are never accepted mid-sequence, and the parked-write slot never overflows. Only the bench's scenarios can show the externally visible results: fetch data equal to the rotated wiring mask, data kept across a fetch, the parked write landing after the restore while a second write is refused, the exact response latencies, and untouched neighbour rows.

// File: rtl/rwl_pkg.sv
package rwl_pkg;
  localparam int unsigned ROM_LAT = 6;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SAVE,
    ST_ONES,
    ST_ZERO,
    ST_READ,
    ST_REST,
    ST_RESP
  } rwl_state_e;
endpackage

// File: rtl/rwl_cell_array.sv
module rwl_cell_array #(
  parameter int unsigned ROWS      = 16,
  parameter int unsigned DW        = 32,
  parameter logic [DW-1:0] WIRE_SEED = 32'hA5C3_0F96,
  localparam int unsigned AW       = $clog2(ROWS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] row_i,
  input  logic          we_i,
  input  logic          wl_a_i,
  input  logic          wl_b_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0]   mem_q [ROWS];
  logic [2*DW-1:0] rot_w;
  logic [DW-1:0]   wire_mask;
  logic [DW-1:0]   bit_en;

  // cells tied to line A where wire_mask is 1
  assign rot_w     = {WIRE_SEED, WIRE_SEED} << (32'(row_i) % DW);
  assign wire_mask = rot_w[2*DW-1:DW];

  for (genvar b = 0; b < DW; b++) begin : g_bit
    assign bit_en[b] = wire_mask[b] ? wl_a_i : wl_b_i;
  end

  assign rdata_o = (wl_a_i && wl_b_i) ? mem_q[row_i] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int r = 0; r < ROWS; r++) mem_q[r] <= '0;
    end else if (we_i) begin
      mem_q[row_i] <= (mem_q[row_i] & ~bit_en) | (wdata_i & bit_en);
    end
  end
endmodule

// File: rtl/rwl_pend_wr.sv
module rwl_pend_wr #(
  parameter int unsigned DW = 32,
  parameter int unsigned AW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [AW-1:0] push_addr_i,
  input  logic [DW-1:0] push_data_i,
  input  logic          pop_i,
  output logic          valid_o,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      addr_o  <= '0;
      data_o  <= '0;
    end else if (push_i) begin
      valid_o <= 1'b1;
      addr_o  <= push_addr_i;
      data_o  <= push_data_i;
    end else if (pop_i) begin
      valid_o <= 1'b0;
    end
  end

  p_no_overflow_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !valid_o);
endmodule

// File: rtl/rwl_seq.sv
module rwl_seq
  import rwl_pkg::*;
#(
  parameter int unsigned DW = 32,
  parameter int unsigned AW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  input  logic          req_rom_i,
  input  logic          req_we_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [DW-1:0] req_wdata_i,
  output logic          req_ready_o,
  output logic          rsp_valid_o,
  output logic [DW-1:0] rsp_rdata_o,
  output logic [AW-1:0] arr_row_o,
  output logic          arr_we_o,
  output logic [DW-1:0] arr_wdata_o,
  output logic          wl_a_o,
  output logic          wl_b_o,
  input  logic [DW-1:0] arr_rdata_i,
  input  logic          pend_valid_i,
  input  logic [AW-1:0] pend_addr_i,
  input  logic [DW-1:0] pend_data_i,
  output logic          pend_push_o,
  output logic          pend_pop_o
);
  rwl_state_e    state_q, state_d;
  logic [AW-1:0] row_q;
  logic [DW-1:0] buf_q;
  logic [DW-1:0] data_q;
  logic          ram_rsp_q;
  logic          idle, mid, acc, rom_rd;

  assign idle   = (state_q == ST_IDLE);
  assign mid    = (state_q inside {ST_SAVE, ST_ONES, ST_ZERO, ST_READ, ST_REST});
  assign rom_rd = !req_we_i && req_rom_i;
  assign acc    = req_valid_i && idle;

  assign req_ready_o = idle || (mid && req_we_i && !pend_valid_i);
  assign pend_push_o = req_valid_i && mid && req_we_i && !pend_valid_i;
  assign pend_pop_o  = (state_q == ST_RESP) && pend_valid_i;
  assign rsp_valid_o = ram_rsp_q || (state_q == ST_RESP);
  assign rsp_rdata_o = data_q;

  always_comb begin
    arr_row_o   = row_q;
    arr_we_o    = 1'b0;
    arr_wdata_o = '0;
    wl_a_o      = 1'b0;
    wl_b_o      = 1'b0;
    state_d     = state_q;
    unique case (state_q)
      ST_IDLE: if (req_valid_i) begin
        arr_row_o = req_addr_i;
        wl_a_o    = 1'b1;
        wl_b_o    = 1'b1;
        if (req_we_i) begin
          arr_we_o    = 1'b1;
          arr_wdata_o = req_wdata_i;
        end else if (req_rom_i) begin
          state_d = ST_SAVE;
        end
      end
      ST_SAVE: begin
        wl_a_o  = 1'b1;
        wl_b_o  = 1'b1;
        state_d = ST_ONES;
      end
      ST_ONES: begin
        wl_a_o      = 1'b1;
        wl_b_o      = 1'b1;
        arr_we_o    = 1'b1;
        arr_wdata_o = '1;
        state_d     = ST_ZERO;
      end
      ST_ZERO: begin
        wl_b_o   = 1'b1;
        arr_we_o = 1'b1;
        state_d  = ST_READ;
      end
      ST_READ: begin
        wl_a_o  = 1'b1;
        wl_b_o  = 1'b1;
        state_d = ST_REST;
      end
      ST_REST: begin
        wl_a_o      = 1'b1;
        wl_b_o      = 1'b1;
        arr_we_o    = 1'b1;
        arr_wdata_o = buf_q;
        state_d     = ST_RESP;
      end
      ST_RESP: begin
        if (pend_valid_i) begin
          arr_row_o   = pend_addr_i;
          wl_a_o      = 1'b1;
          wl_b_o      = 1'b1;
          arr_we_o    = 1'b1;
          arr_wdata_o = pend_data_i;
        end
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      row_q     <= '0;
      buf_q     <= '0;
      data_q    <= '0;
      ram_rsp_q <= 1'b0;
    end else begin
      state_q   <= state_d;
      ram_rsp_q <= acc && !req_we_i && !req_rom_i;
      if (acc) row_q <= req_addr_i;
      if (acc && !req_we_i && !req_rom_i) data_q <= arr_rdata_i;
      if (state_q == ST_SAVE) buf_q  <= arr_rdata_i;
      if (state_q == ST_READ) data_q <= arr_rdata_i;
    end
  end

  p_ram_both_wl_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && !rom_rd) |-> (wl_a_o && wl_b_o));
  p_ones_phase_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ONES) |-> (arr_we_o && wl_a_o && wl_b_o && (&arr_wdata_o)));
  p_zero_phase_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arr_we_o && !wl_a_o) |-> (wl_b_o && arr_wdata_o == '0));
  p_restore_word_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_REST) |-> (arr_wdata_o == $past(arr_rdata_i, 4)));
  p_no_read_busy_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!idle && !req_we_i) |-> !req_ready_o);
  p_rsp_after_restore_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RESP) |-> $past(arr_we_o && wl_a_o && wl_b_o));
endmodule

// File: rtl/rwl_rom_ram_ctrl.sv
module rwl_rom_ram_ctrl #(
  parameter int unsigned ROWS        = 16,
  parameter int unsigned DW          = 32,
  parameter logic [DW-1:0] WIRE_SEED = 32'hA5C3_0F96,
  localparam int unsigned AW         = $clog2(ROWS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  output logic          req_ready_o,
  input  logic          req_rom_i,
  input  logic          req_we_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [DW-1:0] req_wdata_i,
  output logic          rsp_valid_o,
  output logic [DW-1:0] rsp_rdata_o,
  output logic          wl_a_o,
  output logic          wl_b_o
);
  logic [AW-1:0] arr_row;
  logic          arr_we;
  logic [DW-1:0] arr_wdata, arr_rdata;
  logic          pend_valid, pend_push, pend_pop;
  logic [AW-1:0] pend_addr;
  logic [DW-1:0] pend_data;

  rwl_seq #(.DW(DW), .AW(AW)) u_seq (
    .clk_i, .rst_ni,
    .req_valid_i, .req_rom_i, .req_we_i, .req_addr_i, .req_wdata_i,
    .req_ready_o, .rsp_valid_o, .rsp_rdata_o,
    .arr_row_o   (arr_row),
    .arr_we_o    (arr_we),
    .arr_wdata_o (arr_wdata),
    .wl_a_o, .wl_b_o,
    .arr_rdata_i (arr_rdata),
    .pend_valid_i(pend_valid),
    .pend_addr_i (pend_addr),
    .pend_data_i (pend_data),
    .pend_push_o (pend_push),
    .pend_pop_o  (pend_pop)
  );

  rwl_pend_wr #(.DW(DW), .AW(AW)) u_pend (
    .clk_i, .rst_ni,
    .push_i      (pend_push),
    .push_addr_i (req_addr_i),
    .push_data_i (req_wdata_i),
    .pop_i       (pend_pop),
    .valid_o     (pend_valid),
    .addr_o      (pend_addr),
    .data_o      (pend_data)
  );

  rwl_cell_array #(.ROWS(ROWS), .DW(DW), .WIRE_SEED(WIRE_SEED)) u_arr (
    .clk_i, .rst_ni,
    .row_i   (arr_row),
    .we_i    (arr_we),
    .wl_a_i  (wl_a_o),
    .wl_b_i  (wl_b_o),
    .wdata_i (arr_wdata),
    .rdata_o (arr_rdata)
  );
endmodule

// File: tb/sim_rwl_rom_ram_ctrl.sv
`timescale 1ns/1ps
module sim_rwl_rom_ram_ctrl;
  localparam logic [31:0] SEED = 32'hA5C3_0F96;
  localparam int NV = 17;
  // [37:36] op: 0 write, 1 RAM read, 2 fetch, 3 write with rom flag; [35:32] row; [31:0] data
  localparam logic [37:0] VEC [NV] = '{
    {2'd0, 4'd1,  32'hDEAD_BEEF}, {2'd0, 4'd2,  32'h1234_5678},
    {2'd1, 4'd1,  32'h0},         {2'd1, 4'd2,  32'h0},
    {2'd2, 4'd4,  32'h0},         {2'd1, 4'd4,  32'h0},
    {2'd0, 4'd4,  32'hCAFE_F00D}, {2'd2, 4'd4,  32'h0},
    {2'd1, 4'd4,  32'h0},         {2'd2, 4'd0,  32'h0},
    {2'd1, 4'd1,  32'h0},         {2'd0, 4'd15, 32'hFFFF_FFFF},
    {2'd2, 4'd15, 32'h0},         {2'd1, 4'd15, 32'h0},
    {2'd3, 4'd7,  32'h0BAD_F00D}, {2'd1, 4'd7,  32'h0},
    {2'd1, 4'd2,  32'h0}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_rom = 1'b0, req_we = 1'b0;
  logic [3:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic req_ready, rsp_valid, wl_a, wl_b;
  logic [31:0] rsp_rdata;
  int total = 0, bad = 0;
  logic [31:0] shadow [16];
  logic [31:0] got;
  int lat;
  logic wl_acc, wl2_a, wl2_b, wl3_a, wl3_b;

  always #2.5 clk = ~clk;

  rwl_rom_ram_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_rom_i(req_rom), .req_we_i(req_we),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata),
    .wl_a_o(wl_a), .wl_b_o(wl_b)
  );

  function automatic logic [31:0] rmask(int r);
    logic [63:0] t;
    t = {SEED, SEED} << (r % 32);
    return t[63:32];
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_op(int op, int row, logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1;
    req_we    = (op == 0 || op == 3);
    req_rom   = (op == 2 || op == 3);
    req_addr  = 4'(row);
    req_wdata = d;
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    wl_acc = wl_a && wl_b;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1;
    if (op == 0 || op == 3) return;
    while (!rsp_valid && lat < 20) begin
      if (lat == 2) begin wl2_a = wl_a; wl2_b = wl_b; end
      if (lat == 3) begin wl3_a = wl_a; wl3_b = wl_b; end
      @(negedge clk);
      lat++;
    end
    got = rsp_rdata;
  endtask

  initial begin
    #200000;
    bad++; total++;
    $display("FAIL watchdog actual=%0d expected=0", 1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) shadow[i] = '0;
    #12 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 ready", 32'(req_ready), 32'd1);
    chk("R1 rsp_valid", 32'(rsp_valid), 32'd0);
    chk("R1 wl", {30'd0, wl_a, wl_b}, 32'd0);
    do_op(1, 9, 0);
    chk("R1 row zero", got, 32'h0);

    for (int v = 0; v < NV; v++) begin
      int op, row;
      logic [31:0] d;
      op  = int'(VEC[v][37:36]);
      row = int'(VEC[v][35:32]);
      d   = VEC[v][31:0];
      do_op(op, row, d);
      if (op == 0 || op == 3) begin
        shadow[row] = d;
        chk("R2 write ack-free", 32'(rsp_valid), 32'd0);
      end else if (op == 1) begin
        chk("R2 R5 R8 R9 read data", got, shadow[row]);
        chk("R2 read latency", 32'(lat), 32'd1);
        chk("R2 both lines", 32'(wl_acc), 32'd1);
      end else begin
        chk("R3 fetch data", got, rmask(row));
        chk("R3 fetch latency", 32'(lat), 32'd6);
        chk("R4 ones phase lines", {30'd0, wl2_a, wl2_b}, 32'd3);
        chk("R4 zero phase lines", {30'd0, wl3_a, wl3_b}, 32'd1);
      end
    end

    // R7 parked write, R6 reads held off
    do_op(0, 3, 32'h1111_2222);
    @(negedge clk);
    req_valid = 1'b1; req_we = 1'b0; req_rom = 1'b1; req_addr = 4'd3;
    #1;
    chk("R1 idle ready for fetch", 32'(req_ready), 32'd1);
    @(posedge clk);
    @(negedge clk);
    lat = 1;
    req_we = 1'b1; req_rom = 1'b0; req_wdata = 32'h5555_AAAA;
    #1;
    chk("R7 first write ready", 32'(req_ready), 32'd1);
    @(posedge clk);
    @(negedge clk); lat++;
    req_wdata = 32'h7777_7777;
    #1;
    chk("R7 second write held", 32'(req_ready), 32'd0);
    @(negedge clk); lat++;
    req_we = 1'b0; req_rom = 1'b0;
    #1;
    chk("R6 RAM read held", 32'(req_ready), 32'd0);
    req_rom = 1'b1;
    #1;
    chk("R6 fetch held", 32'(req_ready), 32'd0);
    @(negedge clk); lat++;
    req_valid = 1'b0;
    while (!rsp_valid && lat < 20) begin @(negedge clk); lat++; end
    chk("R3 fetch with parked write", rsp_rdata, rmask(3));
    chk("R3 latency with parked write", 32'(lat), 32'd6);
    do_op(1, 3, 0);
    chk("R7 parked write landed", got, 32'h5555_AAAA);
    do_op(1, 4, 0);
    chk("R9 neighbour row", got, shadow[4]);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule